// File: doc/BRIEF.md
# Two-Wire Register Slave with Three-Level Address Select

This block is a two-wire serial slave (I2C and SMBus compatible, standard mode) that lets a host write and read a small bank of byte-wide registers. The bank holds a sticky fault status register at index 0 and a parameterised number of control registers above it. Each control register drives a byte of the `ctrl_o` output. The slave works from a system clock much faster than the bus clock. It synchronises both bus lines, finds START and STOP conditions, and moves data on rising serial clock edges. It drives the data line only through an open-drain pull-low output.

The 7-bit device address comes from two three-level strap inputs. Each strap arrives already decoded as a 2-bit code, so the two straps select one of nine consecutive addresses above a base address. The default base makes strap index 2 answer at 1110010. A write transfer sends a pointer byte and then data bytes that land at the pointer, which advances after each byte. A read after a repeated START returns bytes from the current pointer.

Fault events set bits in the status register, and those bits stay set. The host polls the register to find the cause of a fault and then clears the bits it has handled. While any status bit is set, an open-drain fault line is pulled low.

Top module: `tri_addr_reg_slave`

## Requirements
- R1: The device address is BASE_ADDR + 3*L1 + L0. Each strap code maps to a level as follows: 2'b00 is low (0), 2'b01 is open (1), 2'b10 is high (2), and 2'b11 is treated as open (1). With the default base the addresses run from 0x70 to 0x78.
- R2: After a START, an address byte whose upper seven bits differ from the device address gets no acknowledge. No byte that follows it is acknowledged, and no register changes, until the next START.
- R3: After the eighth bit of a matching address byte, and after the eighth bit of every write data byte, the slave pulls SDA low. The pull starts at the next SCL fall and lasts until the SCL fall after that.
- R4: In a write transfer, the first byte after the address loads the register pointer. Each later byte is written to the register at the pointer. The pointer then advances by one, and it wraps from index NCTRL back to 0.
- R5: An address byte with the read bit set (bit 0 = 1) returns register bytes MSB first, starting at the current pointer. The pointer advances after each byte. Data bits change after SCL falls, and reading continues while the master acknowledges. A master NACK ends the read and leaves SDA released.
- R6: Index 0 is the fault status register, whose bits above NFAULT-1 read as 0. Index k, for k from 1 to NCTRL, is a control register that appears on ctrl_o[8(k-1)+:8]. A pointer beyond NCTRL reads 0x00, and a write to it changes nothing.
- R7: A fault_evt_i bit that is high in a clock cycle sets the matching status bit. The bit stays set, and reading the register does not clear it.
- R8: Writing a 1 to a status bit clears that bit. Writing a 0 to a status bit leaves it unchanged.
- R9: fault_pull_o is 1 (line pulled low) whenever any status bit is set, and 0 when all status bits are clear.
- R10: SDA falling while SCL is high is a START, including a repeated START in the middle of a transfer. SDA rising while SCL is high is a STOP. A STOP returns the slave to idle with SDA released, even partway through a byte, and the next transfer works normally.
- R11: After reset, sda_pull_o and fault_pull_o are 0, every control register is 0, and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_pull_o | output | 1 | 1 pulls the data line low (open drain) |
| a1_code_i | input | 2 | Decoded level of the upper address strap |
| a0_code_i | input | 2 | Decoded level of the lower address strap |
| fault_evt_i | input | NFAULT | Fault event pulses, one per status bit |
| fault_pull_o | output | 1 | 1 pulls the active-low fault line low |
| ctrl_o | output | 8*NCTRL | Control register contents, index 1 in the low byte |

## Verification
The bench builds the block with NCTRL=3, NFAULT=4 and three synchroniser stages. With only three control registers, a short burst runs the pointer past the last control register and back to the status register, so the wrap is reached during both writes and reads. The narrow status register means a write of 1s to bits above NFAULT-1 is also exercised. The third synchroniser stage runs the generate variant with more than two stages and adds bus latency that the bench timing must tolerate. The strap table walks all nine level pairs and the reserved code.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_AACK,
      ST_WR,
      ST_WACK,
      ST_RD,
      ST_RACK,
      ST_RLOAD
   } bus_st_t;

   localparam logic [1:0] LVL_LOW  = 2'b00;
   localparam logic [1:0] LVL_OPEN = 2'b01;
   localparam logic [1:0] LVL_HIGH = 2'b10;

   // reserved code 2'b11 is folded onto the open level
   function automatic logic [1:0] strap_level(input logic [1:0] code);
      return (code == 2'b11) ? LVL_OPEN : code;
   endfunction

endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
   parameter int WIDTH     = 2,
   parameter int STAGES    = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   initial begin
      assert (STAGES >= 2) else $error("i2cs_sync: STAGES must be at least 2");
      assert (WIDTH >= 1)  else $error("i2cs_sync: WIDTH must be positive");
   end

   for (genvar k = 0; k < STAGES; k++) begin : g_stg
      logic [WIDTH-1:0] r;
      if (k == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= {WIDTH{RST_VAL}};
            else        r <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= {WIDTH{RST_VAL}};
            else        r <= g_stg[k-1].r;
         end
      end
   end

   assign q = g_stg[STAGES-1].r;

endmodule

// File: rtl/i2cs_addr_dec.sv
module i2cs_addr_dec
   import i2cs_pkg::*;
#(
   parameter logic [6:0] BASE_ADDR = 7'h70
) (
   input  logic [1:0] a1_code,
   input  logic [1:0] a0_code,
   output logic [6:0] dev_addr
);

   localparam int NUM_ADDR = 9;

   initial begin
      assert (int'(BASE_ADDR) + NUM_ADDR - 1 <= 127)
         else $error("i2cs_addr_dec: address range overflows 7 bits");
   end

   logic [1:0] lvl1, lvl0;
   logic [3:0] sel_idx;

   always_comb begin
      lvl1     = strap_level(a1_code);
      lvl0     = strap_level(a0_code);
      sel_idx  = ({2'b00, lvl1} * 4'd3) + {2'b00, lvl0};
      dev_addr = BASE_ADDR + {3'b000, sel_idx};
   end

endmodule

// File: rtl/i2cs_regbank.sv
module i2cs_regbank #(
   parameter int NCTRL  = 4,
   parameter int NFAULT = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [7:0]         wr_idx,
   input  logic [7:0]         wr_data,
   input  logic [7:0]         rd_idx,
   output logic [7:0]         rd_data,
   input  logic [NFAULT-1:0]  fault_evt,
   output logic               fault_any,
   output logic [8*NCTRL-1:0] ctrl_flat
);

   initial begin
      assert (NCTRL >= 1 && NCTRL <= 254) else $error("i2cs_regbank: NCTRL out of range");
      assert (NFAULT >= 1 && NFAULT <= 8) else $error("i2cs_regbank: NFAULT out of range");
   end

   logic [NFAULT-1:0] status;
   logic [NFAULT-1:0] clr_mask;

   assign clr_mask = (wr_en && wr_idx == 8'd0) ? wr_data[NFAULT-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status <= '0;
      else        status <= (status & ~clr_mask) | fault_evt;
   end

   assign fault_any = |status;

   for (genvar k = 0; k < NCTRL; k++) begin : g_ctrl
      logic [7:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                r <= 8'h00;
         else if (wr_en && wr_idx == 8'(k + 1))     r <= wr_data;
      end
      assign ctrl_flat[8*k +: 8] = r;
   end

   always_comb begin
      rd_data = 8'h00;
      if (rd_idx == 8'd0) begin
         rd_data[NFAULT-1:0] = status;
      end
      for (int k = 0; k < NCTRL; k++) begin
         if (rd_idx == 8'(k + 1)) rd_data = ctrl_flat[8*k +: 8];
      end
   end

   // assertions
   for (genvar i = 0; i < NFAULT; i++) begin : g_fchk
      a_r7_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
         fault_evt[i] |=> status[i]);
      a_r7_bit_sticky: assert property (@(posedge clk) disable iff (!rst_n)
         (status[i] && !clr_mask[i]) |=> status[i]);
      a_r8_one_clears: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_mask[i] && !fault_evt[i]) |=> !status[i]);
   end

   a_r6_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(ctrl_flat));

endmodule

// File: rtl/tri_addr_reg_slave.sv
module tri_addr_reg_slave
   import i2cs_pkg::*;
#(
   parameter logic [6:0] BASE_ADDR   = 7'h70,
   parameter int         NCTRL       = 4,
   parameter int         NFAULT      = 8,
   parameter int         SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_i,
   input  logic               sda_i,
   output logic               sda_pull_o,
   input  logic [1:0]         a1_code_i,
   input  logic [1:0]         a0_code_i,
   input  logic [NFAULT-1:0]  fault_evt_i,
   output logic               fault_pull_o,
   output logic [8*NCTRL-1:0] ctrl_o
);

   localparam int NREGS = NCTRL + 1;
   localparam logic [7:0] LAST_IDX = 8'(NREGS - 1);

   initial begin
      assert (NREGS <= 255) else $error("tri_addr_reg_slave: too many registers");
   end

   // line synchronisation and condition detection
   logic [1:0] bus_s;
   logic       scl_s, sda_s, scl_q, sda_q;

   i2cs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({scl_i, sda_i}),
      .q     (bus_s)
   );

   assign scl_s = bus_s[1];
   assign sda_s = bus_s[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   logic scl_rise, scl_fall, bus_start, bus_stop;
   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign bus_start = scl_s & scl_q & sda_q & ~sda_s;
   assign bus_stop  = scl_s & scl_q & ~sda_q & sda_s;

   // address select
   logic [6:0] dev_addr;

   i2cs_addr_dec #(.BASE_ADDR(BASE_ADDR)) u_adec (
      .a1_code  (a1_code_i),
      .a0_code  (a0_code_i),
      .dev_addr (dev_addr)
   );

   // transfer engine state
   bus_st_t    st;
   logic [2:0] bit_cnt;
   logic [6:0] shreg;
   logic [6:0] tx;
   logic [7:0] ptr;
   logic       rw_bit, ack_drv, ptr_phase, pull;

   logic [7:0] rx_byte, ptr_inc, rd_data;
   logic       byte_done, wr_en;

   assign rx_byte   = {shreg, sda_s};
   assign byte_done = scl_rise && (bit_cnt == 3'd7);
   assign ptr_inc   = (ptr == LAST_IDX) ? 8'd0 : ptr + 8'd1;
   assign wr_en     = (st == ST_WR) && byte_done && !ptr_phase && !bus_start && !bus_stop;

   i2cs_regbank #(.NCTRL(NCTRL), .NFAULT(NFAULT)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_idx    (ptr),
      .wr_data   (rx_byte),
      .rd_idx    (ptr),
      .rd_data   (rd_data),
      .fault_evt (fault_evt_i),
      .fault_any (fault_pull_o),
      .ctrl_flat (ctrl_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         bit_cnt   <= 3'd0;
         shreg     <= 7'd0;
         tx        <= 7'd0;
         ptr       <= 8'd0;
         rw_bit    <= 1'b0;
         ack_drv   <= 1'b0;
         ptr_phase <= 1'b0;
         pull      <= 1'b0;
      end else if (bus_start) begin
         st      <= ST_ADDR;
         bit_cnt <= 3'd0;
         ack_drv <= 1'b0;
         pull    <= 1'b0;
      end else if (bus_stop) begin
         st   <= ST_IDLE;
         pull <= 1'b0;
      end else begin
         unique case (st)
            ST_IDLE: ;
            ST_ADDR: if (scl_rise) begin
               shreg   <= rx_byte[6:0];
               bit_cnt <= bit_cnt + 3'd1;
               if (byte_done) begin
                  if (shreg == dev_addr) begin
                     rw_bit  <= sda_s;
                     ack_drv <= 1'b0;
                     st      <= ST_AACK;
                  end else begin
                     st <= ST_IDLE;
                  end
               end
            end
            ST_AACK: if (scl_fall) begin
               if (!ack_drv) begin
                  pull    <= 1'b1;
                  ack_drv <= 1'b1;
               end else if (rw_bit) begin
                  tx      <= rd_data[6:0];
                  pull    <= ~rd_data[7];
                  ptr     <= ptr_inc;
                  bit_cnt <= 3'd0;
                  st      <= ST_RD;
               end else begin
                  pull      <= 1'b0;
                  bit_cnt   <= 3'd0;
                  ptr_phase <= 1'b1;
                  st        <= ST_WR;
               end
            end
            ST_WR: if (scl_rise) begin
               shreg   <= rx_byte[6:0];
               bit_cnt <= bit_cnt + 3'd1;
               if (byte_done) begin
                  if (ptr_phase) begin
                     ptr       <= rx_byte;
                     ptr_phase <= 1'b0;
                  end else begin
                     ptr <= ptr_inc;
                  end
                  ack_drv <= 1'b0;
                  st      <= ST_WACK;
               end
            end
            ST_WACK: if (scl_fall) begin
               if (!ack_drv) begin
                  pull    <= 1'b1;
                  ack_drv <= 1'b1;
               end else begin
                  pull    <= 1'b0;
                  bit_cnt <= 3'd0;
                  st      <= ST_WR;
               end
            end
            ST_RD: begin
               if (scl_rise) begin
                  bit_cnt <= bit_cnt + 3'd1;
                  if (byte_done) st <= ST_RACK;
               end else if (scl_fall) begin
                  pull <= ~tx[6];
                  tx   <= {tx[5:0], 1'b0};
               end
            end
            ST_RACK: begin
               if (scl_fall) begin
                  pull <= 1'b0;
               end else if (scl_rise) begin
                  st <= sda_s ? ST_IDLE : ST_RLOAD;
               end
            end
            ST_RLOAD: if (scl_fall) begin
               tx      <= rd_data[6:0];
               pull    <= ~rd_data[7];
               ptr     <= ptr_inc;
               bit_cnt <= 3'd0;
               st      <= ST_RD;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign sda_pull_o = pull;

   // assertions
   a_r10_start_to_addr: assert property (@(posedge clk) disable iff (!rst_n)
      bus_start |=> (st == ST_ADDR && !sda_pull_o));

   a_r10_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_stop && !bus_start) |=> (st == ST_IDLE && !sda_pull_o));

   a_r2_mismatch_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_ADDR && byte_done && shreg != dev_addr) |=> (st == ST_IDLE));

   a_r3_ack_held: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == ST_AACK || st == ST_WACK) && ack_drv && !scl_fall && !bus_start && !bus_stop)
      |=> sda_pull_o);

   a_r5_master_ack_free: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RACK && scl_rise) |-> !sda_pull_o);

   a_r2_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE) |-> !sda_pull_o);

endmodule

// File: tb/tb_tri_addr_reg_slave.sv
module tb_tri_addr_reg_slave;

   localparam int NCTRL  = 3;
   localparam int NFAULT = 4;
   localparam int QCLK   = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic sda_bus;
   logic sda_pull, fault_pull;
   logic [1:0] a1_code = 2'b00;
   logic [1:0] a0_code = 2'b10;
   logic [NFAULT-1:0] fault_evt = '0;
   logic [8*NCTRL-1:0] ctrl;

   int checks = 0;
   int fails  = 0;
   logic [6:0] dev = 7'h72;

   always #4 clk = ~clk;

   assign sda_bus = sda_m & ~sda_pull;

   tri_addr_reg_slave #(
      .BASE_ADDR   (7'h70),
      .NCTRL       (NCTRL),
      .NFAULT      (NFAULT),
      .SYNC_STAGES (3)
   ) dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .scl_i        (scl_m),
      .sda_i        (sda_bus),
      .sda_pull_o   (sda_pull),
      .a1_code_i    (a1_code),
      .a0_code_i    (a0_code),
      .fault_evt_i  (fault_evt),
      .fault_pull_o (fault_pull),
      .ctrl_o       (ctrl)
   );

   typedef struct packed {
      logic [1:0] a1;
      logic [1:0] a0;
      logic [6:0] addr;
   } strap_vec_t;

   localparam strap_vec_t STRAPS [10] = '{
      '{2'b00, 2'b00, 7'h70}, '{2'b00, 2'b01, 7'h71}, '{2'b00, 2'b10, 7'h72},
      '{2'b01, 2'b00, 7'h73}, '{2'b01, 2'b01, 7'h74}, '{2'b01, 2'b10, 7'h75},
      '{2'b10, 2'b00, 7'h76}, '{2'b10, 2'b01, 7'h77}, '{2'b10, 2'b10, 7'h78},
      '{2'b11, 2'b11, 7'h74}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic qwait();
      repeat (QCLK) @(posedge clk);
      #1;
   endtask

   task automatic bus_start();
      sda_m = 1'b1; qwait();
      scl_m = 1'b1; qwait();
      sda_m = 1'b0; qwait();
      scl_m = 1'b0; qwait();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; qwait();
      scl_m = 1'b1; qwait();
      sda_m = 1'b1; qwait();
   endtask

   task automatic bit_xfer(input logic b, output logic r);
      sda_m = b;    qwait();
      scl_m = 1'b1; qwait();
      r = sda_bus;  qwait();
      scl_m = 1'b0; qwait();
   endtask

   task automatic wr_byte(input logic [7:0] data, output logic ack);
      logic r;
      for (int i = 7; i >= 0; i--) bit_xfer(data[i], r);
      bit_xfer(1'b1, r);
      ack = ~r;
   endtask

   task automatic rd_byte(input logic master_ack, output logic [7:0] data);
      logic r;
      for (int i = 7; i >= 0; i--) begin
         bit_xfer(1'b1, r);
         data[i] = r;
      end
      bit_xfer(~master_ack, r);
   endtask

   task automatic write_reg(input logic [7:0] idx, input logic [7:0] data);
      logic a0, a1, a2;
      bus_start();
      wr_byte({dev, 1'b0}, a0);
      wr_byte(idx, a1);
      wr_byte(data, a2);
      bus_stop();
      chk("R3 write acks", {29'd0, a0, a1, a2}, 32'h7);
   endtask

   task automatic read_reg(input logic [7:0] idx, output logic [7:0] data);
      logic a0, a1, a2;
      bus_start();
      wr_byte({dev, 1'b0}, a0);
      wr_byte(idx, a1);
      bus_start();
      wr_byte({dev, 1'b1}, a2);
      rd_byte(1'b0, data);
      bus_stop();
      chk("R3 read-setup acks", {29'd0, a0, a1, a2}, 32'h7);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic ack, a0, a1, a2, r;
      logic [7:0] d;
      logic [8*NCTRL-1:0] snap;

      repeat (5) @(posedge clk);
      #1 rst_n = 1'b1;
      qwait();

      // R11 reset state
      chk("R11 sda_pull after reset", {31'd0, sda_pull}, 32'd0);
      chk("R11 fault_pull after reset", {31'd0, fault_pull}, 32'd0);
      chk("R11 ctrl after reset", {8'd0, ctrl}, 32'd0);

      // R1 / R2 strap table
      foreach (STRAPS[i]) begin
         a1_code = STRAPS[i].a1;
         a0_code = STRAPS[i].a0;
         qwait();
         bus_start();
         wr_byte({STRAPS[i].addr, 1'b0}, ack);
         bus_stop();
         chk($sformatf("R1 match addr %0h", STRAPS[i].addr), {31'd0, ack}, 32'd1);
         bus_start();
         wr_byte({STRAPS[i].addr ^ 7'h40, 1'b0}, ack);
         bus_stop();
         chk("R2 foreign address nack", {31'd0, ack}, 32'd0);
      end
      a1_code = 2'b00;
      a0_code = 2'b10;
      qwait();

      // R11 pointer reset: read without setting pointer returns index 0 (status = 0)
      bus_start();
      wr_byte({dev, 1'b1}, ack);
      rd_byte(1'b0, d);
      bus_stop();
      chk("R11 pointer at 0 read", {24'd0, d}, 32'h00);

      // R4 pointer and burst write
      bus_start();
      wr_byte({dev, 1'b0}, a0);
      wr_byte(8'h01, a1);
      wr_byte(8'hA5, a2);
      wr_byte(8'h3C, ack);
      bus_stop();
      chk("R3 burst acks", {28'd0, a0, a1, a2, ack}, 32'hF);
      chk("R4 reg1 written", {24'd0, ctrl[7:0]}, 32'hA5);
      chk("R4 reg2 written", {24'd0, ctrl[15:8]}, 32'h3C);

      // R4 wrap: index 3 then index 0
      bus_start();
      wr_byte({dev, 1'b0}, a0);
      wr_byte(8'h03, a1);
      wr_byte(8'h11, a2);
      wr_byte(8'h22, ack);
      bus_stop();
      chk("R4 reg3 written", {24'd0, ctrl[23:16]}, 32'h11);
      chk("R4 wrap ctrl untouched", {8'd0, ctrl}, 32'h113CA5);

      // R5 burst read with repeated start, wraps to status
      bus_start();
      wr_byte({dev, 1'b0}, a0);
      wr_byte(8'h01, a1);
      bus_start();
      wr_byte({dev, 1'b1}, a2);
      rd_byte(1'b1, d);
      chk("R5 read byte 1", {24'd0, d}, 32'hA5);
      rd_byte(1'b1, d);
      chk("R5 read byte 2", {24'd0, d}, 32'h3C);
      rd_byte(1'b1, d);
      chk("R5 read byte 3", {24'd0, d}, 32'h11);
      rd_byte(1'b0, d);
      chk("R5 read wrapped status", {24'd0, d}, 32'h00);
      chk("R5 released after nack", {31'd0, sda_pull}, 32'd0);
      bus_stop();
      chk("R10 released after stop", {31'd0, sda_pull}, 32'd0);

      // R7 / R9 fault events
      @(posedge clk); #1 fault_evt = 4'b0101;
      @(posedge clk); #1 fault_evt = 4'b0000;
      qwait();
      chk("R9 fault line active", {31'd0, fault_pull}, 32'd1);
      read_reg(8'h00, d);
      chk("R7 status first read", {24'd0, d}, 32'h05);
      read_reg(8'h00, d);
      chk("R7 status not cleared by read", {24'd0, d}, 32'h05);

      // R8 write-one-to-clear
      write_reg(8'h00, 8'hF1);
      read_reg(8'h00, d);
      chk("R8 bit0 cleared only", {24'd0, d}, 32'h04);
      chk("R9 fault line still active", {31'd0, fault_pull}, 32'd1);
      write_reg(8'h00, 8'h00);
      read_reg(8'h00, d);
      chk("R8 zero write keeps bits", {24'd0, d}, 32'h04);
      write_reg(8'h00, 8'h04);
      chk("R9 fault line released", {31'd0, fault_pull}, 32'd0);

      // R6 out-of-range pointer
      snap = ctrl;
      write_reg(8'h10, 8'h77);
      chk("R6 out-of-range write ignored", {8'd0, ctrl}, {8'd0, snap});
      read_reg(8'h10, d);
      chk("R6 out-of-range reads zero", {24'd0, d}, 32'h00);

      // R2 foreign address followed by data
      bus_start();
      wr_byte({7'h30, 1'b0}, a0);
      wr_byte(8'h02, a1);
      wr_byte(8'hEE, a2);
      bus_stop();
      chk("R2 no ack for foreign transfer", {29'd0, a0, a1, a2}, 32'h0);
      chk("R2 registers unchanged", {8'd0, ctrl}, {8'd0, snap});

      // R10 stop in the middle of a byte
      bus_start();
      bit_xfer(1'b1, r);
      bit_xfer(1'b1, r);
      bit_xfer(1'b1, r);
      bus_stop();
      chk("R10 idle after aborted byte", {31'd0, sda_pull}, 32'd0);
      write_reg(8'h02, 8'h5A);
      chk("R10 transfer after abort", {24'd0, ctrl[15:8]}, 32'h5A);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule